// File: doc/BRIEF.md
# Reset Boot Loader Sequencer

This block governs how a processor core comes out of reset. While the reset input is low it keeps the core parked. It does this through a single initialisation level that empties the core's stacks, sets every interrupt mask bit and zeroes the mode/status register. The same level keeps the run enable low. The reset input asserts asynchronously and is released through a two-stage synchroniser, so internal state leaves reset on a clock edge.

Once reset is released, the sequencer samples a memory-map strap. If the strap is 1, the core is started at once with a fetch address of zero. If the strap is 0, the sequencer first waits until no external bus request is pending. It then reads a block of bytes from an external byte-wide boot memory, using a dedicated boot select strobe and a read strobe. Every three bytes are packed into one 24-bit instruction word, and each word is written to internal program memory. After the last word it pulses a done flag and starts the core at address zero. The 16-bit byte address is split across two buses. Its low 14 bits go out on the address bus. Its top 2 bits go out on the pins that drive data-bus lines 23 and 22. Bytes return on data-bus lines 15 to 8.

If a bus request arrives during loading, the access in progress is completed. No further access starts until the request is withdrawn, and loading then resumes at the next byte address.

Top module: `boot_seq_top`

## Requirements
- R1: While `rst_n` is low, `core_init` is 1 and `boot_cs`, `mem_rd`, `pm_we`, `boot_done` and `core_run` are 0. After `rst_n` rises, `core_init` stays 1 through the first rising clock edge and falls at the second.
- R2: With `map_strap` = 1 at release, no boot access ever occurs, `boot_done` never pulses, and `core_run` rises at the third rising edge after `rst_n` rises.
- R3: With `map_strap` = 0, no boot access starts while `bus_req` is 1. Boot begins only after `bus_req` falls.
- R4: Byte k of the boot image is read from byte address `BOOT_BASE`+k. Bits 13:0 of that address appear on `addr_o` and bits 15:14 on `data_hi_o`, and the address is stable for the whole access.
- R5: The byte is taken from `boot_byte_i`, which carries data lines 15:8. Bytes 3n, 3n+1 and 3n+2 form word n, with the first byte in bits 23:16 and the third in bits 7:0. Word n is written with `pm_we` = 1, `pm_addr` = n and `pm_wdata` = that word, and exactly `WORDS` words are written.
- R6: Every access holds `boot_cs` and `mem_rd` both at 1 for exactly `WAIT_CYC`+1 consecutive cycles.
- R7: A `bus_req` raised during loading lets the current access finish. No new access starts while `bus_req` is 1, and the first access after it falls uses the next unread byte address.
- R8: `boot_done` is 1 for exactly one cycle, the same cycle as the final `pm_we`. `core_run` is 1 from the following cycle on.
- R9: `core_run` and `boot_cs` are never 1 together, and `run_pc` is 0 whenever `core_run` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| map_strap | input | 1 | Memory-map strap; 0 enables loading |
| bus_req | input | 1 | External bus request |
| boot_byte_i | input | 8 | Boot byte from data lines 15:8 |
| core_init | output | 1 | Empties stacks, masks interrupts, clears mode/status |
| boot_cs | output | 1 | Boot memory select strobe |
| mem_rd | output | 1 | Read strobe |
| addr_o | output | ADDR_W | Low byte-address bits on the address bus |
| data_hi_o | output | HI_W | Top byte-address bits for data lines 23:22 |
| pm_we | output | 1 | Program memory write enable |
| pm_addr | output | ADDR_W | Program memory word address |
| pm_wdata | output | 24 | Packed instruction word |
| boot_done | output | 1 | One-cycle loading-complete pulse |
| core_run | output | 1 | Core run enable |
| run_pc | output | ADDR_W | First fetch address |

## Verification
Each result is due a known number of cycles after its cause. The byte address and strobes appear in the cycle after the sequencer leaves its gap or decide state. The byte is captured on the edge that ends the (`WAIT_CYC`+1)-th strobe cycle. The word write shows one cycle after the third byte's capture, together with `boot_done` for the last word, and `core_run` follows one cycle after that. `core_init` falls on the second edge after reset release, and with the strap set `core_run` rises on the third. The bench drives inputs and samples every output on the falling clock edge. Its monitor compares each access start and each word write against a queue of expected items as they occur, so the checks are tied to these events rather than to fixed delays from the stimulus.

// File: rtl/boot_pkg.sv
package boot_pkg;
  localparam int WORD_W = 24;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_DECIDE = 3'd0,
    ST_GAP    = 3'd1,
    ST_ACC    = 3'd2,
    ST_FINISH = 3'd3,
    ST_RUN    = 3'd4
  } boot_st_e;
endpackage

// File: rtl/boot_rst_sync.sv
module boot_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/boot_addr_gen.sv
module boot_addr_gen #(
  parameter int ADDR_W = 14,
  parameter int HI_W   = 2,
  parameter logic [ADDR_W+HI_W-1:0] BASE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  output logic [ADDR_W-1:0] addr_lo,
  output logic [HI_W-1:0]   addr_hi
);
  localparam int BA_W = ADDR_W + HI_W;

  logic [BA_W-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (step) ptr_d = ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= BASE;
    else        ptr_q <= ptr_d;
  end

  assign {addr_hi, addr_lo} = ptr_q;
endmodule

// File: rtl/boot_packer.sv
module boot_packer import boot_pkg::*; #(
  parameter int WORDS = 32,
  parameter int PA_W  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              last_word,
  output logic              pm_we,
  output logic [PA_W-1:0]   pm_addr,
  output logic [WORD_W-1:0] pm_wdata
);
  localparam int WI_W = $clog2(WORDS + 1);
  localparam logic [WI_W-1:0] IDX_LAST = WI_W'(WORDS - 1);

  logic [1:0]          lane_q, lane_d;
  logic [2*BYTE_W-1:0] sh_q, sh_d;
  logic [WI_W-1:0]     idx_q, idx_d;
  logic                we_d;
  logic [PA_W-1:0]     wa_d;
  logic [WORD_W-1:0]   wd_d;

  assign last_word = (lane_q == 2'd2) && (idx_q == IDX_LAST);

  always_comb begin
    lane_d = lane_q;
    sh_d   = sh_q;
    idx_d  = idx_q;
    we_d   = 1'b0;
    wa_d   = pm_addr;
    wd_d   = pm_wdata;
    if (take) begin
      if (lane_q == 2'd2) begin
        we_d   = 1'b1;
        wa_d   = PA_W'(idx_q);
        wd_d   = {sh_q, byte_i};
        lane_d = 2'd0;
        idx_d  = idx_q + 1'b1;
      end else begin
        sh_d   = {sh_q[BYTE_W-1:0], byte_i};
        lane_d = lane_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_q   <= '0;
      sh_q     <= '0;
      idx_q    <= '0;
      pm_we    <= 1'b0;
      pm_addr  <= '0;
      pm_wdata <= '0;
    end else begin
      lane_q   <= lane_d;
      sh_q     <= sh_d;
      idx_q    <= idx_d;
      pm_we    <= we_d;
      pm_addr  <= wa_d;
      pm_wdata <= wd_d;
    end
  end
endmodule

// File: rtl/boot_seq_top.sv
module boot_seq_top import boot_pkg::*; #(
  parameter int ADDR_W   = 14,
  parameter int HI_W     = 2,
  parameter int WORDS    = 32,
  parameter int WAIT_CYC = 2,
  parameter logic [ADDR_W+HI_W-1:0] BOOT_BASE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              map_strap,
  input  logic              bus_req,
  input  logic [BYTE_W-1:0] boot_byte_i,
  output logic              core_init,
  output logic              boot_cs,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] addr_o,
  output logic [HI_W-1:0]   data_hi_o,
  output logic              pm_we,
  output logic [ADDR_W-1:0] pm_addr,
  output logic [WORD_W-1:0] pm_wdata,
  output logic              boot_done,
  output logic              core_run,
  output logic [ADDR_W-1:0] run_pc
);
  localparam int CW = (WAIT_CYC > 0) ? $clog2(WAIT_CYC + 1) : 1;
  localparam logic [CW-1:0] CNT_END = CW'(WAIT_CYC);

  logic           rst_n_sync;
  boot_st_e       st_q, st_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic           take;
  logic           last_word;

  boot_rst_sync u_rsync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    take  = 1'b0;
    unique case (st_q)
      ST_DECIDE: begin
        if (map_strap)     st_d = ST_RUN;
        else if (!bus_req) st_d = ST_ACC;
      end
      ST_GAP: begin
        if (!bus_req) st_d = ST_ACC;
      end
      ST_ACC: begin
        if (cnt_q == CNT_END) begin
          take  = 1'b1;
          cnt_d = '0;
          st_d  = last_word ? ST_FINISH : ST_GAP;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_FINISH: st_d = ST_RUN;
      default:   st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      st_q  <= ST_DECIDE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  boot_addr_gen #(
    .ADDR_W (ADDR_W),
    .HI_W   (HI_W),
    .BASE   (BOOT_BASE)
  ) u_addr (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .step    (take),
    .addr_lo (addr_o),
    .addr_hi (data_hi_o)
  );

  boot_packer #(
    .WORDS (WORDS),
    .PA_W  (ADDR_W)
  ) u_pack (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .take      (take),
    .byte_i    (boot_byte_i),
    .last_word (last_word),
    .pm_we     (pm_we),
    .pm_addr   (pm_addr),
    .pm_wdata  (pm_wdata)
  );

  assign core_init = ~rst_n_sync;
  assign boot_cs   = (st_q == ST_ACC);
  assign mem_rd    = (st_q == ST_ACC);
  assign boot_done = (st_q == ST_FINISH);
  assign core_run  = (st_q == ST_RUN);
  assign run_pc    = '0;
endmodule

// File: rtl/boot_seq_chk.sv
module boot_seq_chk #(
  parameter int ADDR_W   = 14,
  parameter int HI_W     = 2,
  parameter int WAIT_CYC = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              core_init,
  input logic              bus_req,
  input logic              boot_cs,
  input logic              mem_rd,
  input logic [ADDR_W-1:0] addr_o,
  input logic [HI_W-1:0]   data_hi_o,
  input logic              pm_we,
  input logic              boot_done,
  input logic              core_run
);
  localparam int LW = $clog2(WAIT_CYC + 3);
  localparam logic [LW-1:0] LEN_MAX = LW'(WAIT_CYC + 1);

  logic [LW-1:0] len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       len_q <= '0;
    else if (boot_cs) len_q <= (len_q == LEN_MAX) ? len_q : len_q + 1'b1;
    else              len_q <= '0;
  end

  p_quiet_in_init_r1: assert property (@(posedge clk) disable iff (!rst_n)
    core_init |-> (!boot_cs && !pm_we && !core_run && !boot_done));

  p_no_start_under_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(boot_cs) |-> !$past(bus_req));

  p_addr_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_cs && $past(boot_cs)) |-> $stable({data_hi_o, addr_o}));

  p_rd_with_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    boot_cs |-> mem_rd);

  p_access_len_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    boot_cs |-> (len_q < LEN_MAX));

  p_access_len_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(boot_cs) |-> (len_q == LEN_MAX));

  p_done_with_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |-> pm_we);

  p_run_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |=> core_run);

  p_run_excludes_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    core_run |-> !boot_cs);
endmodule

bind boot_seq_top boot_seq_chk #(
  .ADDR_W   (ADDR_W),
  .HI_W     (HI_W),
  .WAIT_CYC (WAIT_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .core_init (core_init),
  .bus_req   (bus_req),
  .boot_cs   (boot_cs),
  .mem_rd    (mem_rd),
  .addr_o    (addr_o),
  .data_hi_o (data_hi_o),
  .pm_we     (pm_we),
  .boot_done (boot_done),
  .core_run  (core_run)
);

// File: tb/boot_seq_top_tb_top.sv
module boot_seq_top_tb_top;
  localparam int ADDR_W   = 14;
  localparam int HI_W     = 2;
  localparam int WORDS    = 32;
  localparam int WAIT_CYC = 2;
  localparam logic [15:0] BASE = 16'hBFE0;

  logic              clk;
  logic              rst_n;
  logic              map_strap;
  logic              bus_req;
  logic [7:0]        boot_byte;
  logic              core_init, boot_cs, mem_rd, pm_we, boot_done, core_run;
  logic [ADDR_W-1:0] addr_o, pm_addr, run_pc;
  logic [HI_W-1:0]   data_hi_o;
  logic [23:0]       pm_wdata;

  int vectors = 0;
  int errors  = 0;
  int cs_starts = 0;
  int words_seen = 0;
  int done_cnt = 0;
  int run_len = 0;
  bit prev_cs = 1'b0;
  bit stall_chk = 1'b0;
  bit finished = 1'b0;

  logic [15:0] exp_addr_q[$];
  logic [23:0] exp_word_q[$];

  boot_seq_top #(
    .ADDR_W    (ADDR_W),
    .HI_W      (HI_W),
    .WORDS     (WORDS),
    .WAIT_CYC  (WAIT_CYC),
    .BOOT_BASE (BASE)
  ) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .map_strap   (map_strap),
    .bus_req     (bus_req),
    .boot_byte_i (boot_byte),
    .core_init   (core_init),
    .boot_cs     (boot_cs),
    .mem_rd      (mem_rd),
    .addr_o      (addr_o),
    .data_hi_o   (data_hi_o),
    .pm_we       (pm_we),
    .pm_addr     (pm_addr),
    .pm_wdata    (pm_wdata),
    .boot_done   (boot_done),
    .core_run    (core_run),
    .run_pc      (run_pc)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [7:0] img(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  always_comb boot_byte = img({data_hi_o, addr_o});

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  task automatic push_image();
    for (int w = 0; w < WORDS; w++) begin
      logic [15:0] a;
      a = BASE + 16'(3 * w);
      exp_word_q.push_back({img(a), img(a + 16'd1), img(a + 16'd2)});
      for (int b = 0; b < 3; b++) exp_addr_q.push_back(a + 16'(b));
    end
  endtask

  // Monitor: compares accesses and word writes as they appear
  always @(negedge clk) begin
    if (boot_cs) begin
      if (!prev_cs) begin
        cs_starts++;
        if (exp_addr_q.size() == 0) check("R4 R7 extra access", 32'd1, 32'd0);
        else check("R4 R7 byte address", {16'd0, data_hi_o, addr_o}, {16'd0, exp_addr_q.pop_front()});
      end
      run_len++;
      if (!mem_rd) check("R6 read strobe", 32'd0, 32'd1);
      if (core_run) check("R9 run with select", 32'd1, 32'd0);
      if (stall_chk) check("R7 access during request", 32'd1, 32'd0);
    end else if (prev_cs) begin
      check("R6 access length", run_len, WAIT_CYC + 1);
      run_len = 0;
    end
    prev_cs = boot_cs;
    if (pm_we) begin
      if (exp_word_q.size() == 0) check("R5 extra write", 32'd1, 32'd0);
      else begin
        check("R5 word data", {8'd0, pm_wdata}, {8'd0, exp_word_q.pop_front()});
        check("R5 word address", pm_addr, words_seen);
        check("R8 done with last write", boot_done, (words_seen == WORDS - 1));
      end
      words_seen++;
    end
    if (boot_done) done_cnt++;
    if (core_run && run_pc !== '0) check("R9 run_pc", run_pc, 32'd0);
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0; map_strap = 1'b1; bus_req = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 core_init", core_init, 1);
    check("R1 boot_cs", boot_cs, 0);
    check("R1 pm_we", pm_we, 0);
    check("R1 core_run", core_run, 0);
    check("R1 boot_done", boot_done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 init after first edge", core_init, 1);
    @(negedge clk);
    check("R1 init after second edge", core_init, 0);
    check("R2 not yet running", core_run, 0);
    @(negedge clk);
    check("R2 run on third edge", core_run, 1);
    check("R9 run_pc", run_pc, 0);
    repeat (20) @(negedge clk);
    check("R2 no boot access", cs_starts, 0);
    check("R2 no done pulse", done_cnt, 0);

    // Boot path with a request pending at release
    rst_n = 1'b0; map_strap = 1'b0; bus_req = 1'b1;
    #1;
    check("R1 async init", core_init, 1);
    check("R1 async run drop", core_run, 0);
    push_image();
    @(negedge clk);
    rst_n = 1'b1;
    repeat (30) @(negedge clk);
    check("R3 no access under request", cs_starts, 0);
    bus_req = 1'b0;
    while (words_seen < 10) @(negedge clk);
    bus_req = 1'b1;
    repeat (WAIT_CYC + 3) @(negedge clk);
    stall_chk = 1'b1;
    begin
      int s0;
      s0 = cs_starts;
      repeat (20) @(negedge clk);
      check("R7 stalled", cs_starts, s0);
    end
    stall_chk = 1'b0;
    bus_req = 1'b0;
    while (done_cnt == 0) @(negedge clk);
    @(negedge clk);
    check("R8 run after done", core_run, 1);
    check("R9 run_pc after boot", run_pc, 0);
    repeat (10) @(negedge clk);
    check("R5 words written", words_seen, WORDS);
    check("R8 single done", done_cnt, 1);
    check("R4 all bytes read", exp_addr_q.size(), 0);
    check("R5 all words seen", exp_word_q.size(), 0);
    summary();
  end
endmodule